// File: doc/BRIEF.md
# MDIO Management Slave with Indirect Extended Register Window

This block is the management-side slave of a 10/100 Ethernet transceiver. It runs on the MDC clock and samples MDIO on every rising edge. It recognises Clause 22 read and write frames whose PHY address matches the address captured from the strap pins when reset is released. For a read, it drives the 16-bit reply onto MDIO. Frames for other addresses, frames with an invalid opcode, and frames with a short preamble leave no trace.

A small set of direct registers sits behind the serial engine:
- a basic control word, which exports the internal-loopback and isolate controls;
- an interrupt mask;
- a sticky interrupt status word, whose bits are set by event inputs and cleared by reading it;
- an address-offset register.

A data register forwards each access to a 16-bit extended space. In that space, one word holds the wake-detection enable, one holds the wake interrupt mode and pulse width, and three words hold a 48-bit wake address.

Top module: `mdio_window_slave`

## Requirements
- R1: After reset, mdio_oe is 0, mdio_o is 0, irq_n is 1, and every exported control field, including wake_addr, is 0.
- R2: A read frame with a matching PHY address is framed as follows. The frame is 32 ones, start bits 0 then 1, opcode 10, the PHY address, the register address, and turnaround. Bit k is sampled on MDC rising edge k. Call E the edge that samples the last register-address bit. During the first turnaround bit, after E, MDIO is left undriven. After edge E+1, mdio_o is driven to 0. The 16 data bits follow MSB first, changing on edges E+2 through E+17. MDIO is released after edge E+18.
- R3: A write frame has opcode 01, two turnaround bits, then 16 data bits MSB first. Writing register 0x00 stores the full word, and the stored value reads back unchanged. Bit 14 of register 0x00 drives loopback_en, and bit 10 drives isolate_en.
- R4: A frame whose PHY address differs from the latched address, or whose opcode is 00 or 11, changes no register and never enables the MDIO driver.
- R5: strap_phy_addr is latched on the first MDC rising edge after rst_n rises. Later changes on the strap pins do not alter the address the slave answers to.
- R6: A frame starts only after at least 32 consecutive ones followed by a 0. A frame preceded by only 31 ones is ignored.
- R7: Unimplemented direct and extended registers read as 0x0000, and writes to them change nothing.
- R8: Register 0x1E holds a 16-bit extended address and reads back. A read or write of register 0x1F reaches the extended register at that address. Extended 0x4004, 0x4005 and 0x4006 form wake_addr, most significant word in 0x4004.
- R9: Extended register 0x4000 bit 2 drives wake_en. In extended register 0x4003, bit 7 drives wake_pulse_mode (1 = pulse, 0 = level), and bits 9:8 drive wake_pulse_width. Both words read back in full.
- R10: Each irq_evt bit that is high at an MDC edge sets the matching bit of status register 0x13, where bit 6 is the wake event. Status bits hold until register 0x13 is read. That read returns them and clears them. Writes to 0x13 are discarded.
- R11: irq_n is low exactly while some status bit and the same bit of mask register 0x12 are both set.
- R12: An event that arrives on the same edge at which a read of 0x13 captures and clears the status survives that clear. The read returns the old value, and the next read reports the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_phy_addr | input | 5 | Strap-pin PHY address, latched after reset |
| mdio_i | input | 1 | MDIO line as seen by the slave |
| mdio_o | output | 1 | MDIO value driven during reads |
| mdio_oe | output | 1 | MDIO driver enable |
| irq_evt | input | 16 | Event inputs, one per status bit |
| irq_n | output | 1 | Interrupt request, active low |
| loopback_en | output | 1 | Internal loopback control |
| isolate_en | output | 1 | xMII isolate control |
| wake_en | output | 1 | Wake-frame detection enable |
| wake_pulse_mode | output | 1 | Wake interrupt: 0 level, 1 pulse |
| wake_pulse_width | output | 2 | Wake interrupt pulse width select |
| wake_addr | output | 48 | Wake address, first word most significant |

## Verification
A bit counter that slips by one cycle shows up at the ports within the same frame. The turnaround zero appears on the wrong edge, or the read-back word comes out shifted by one place. Both are checked on every read.

A wrong decode of the PHY address or opcode shows the same way. The MDIO driver enables when it should not, or a control output moves after a frame that should have been ignored.

Status that is lost or cleared too early shows up on the next read of 0x13 and on irq_n one edge after the event. The same-edge set/clear race is exercised by pulsing an event exactly at the capture edge.

// File: rtl/mdio_win_pkg.sv
package mdio_win_pkg;

    // Direct register numbers (fixed by the management frame protocol)
    localparam logic [4:0] RA_CTRL  = 5'h00;
    localparam logic [4:0] RA_IMASK = 5'h12;
    localparam logic [4:0] RA_ISTAT = 5'h13;
    localparam logic [4:0] RA_XADDR = 5'h1E;
    localparam logic [4:0] RA_XDATA = 5'h1F;

    // Extended register numbers
    localparam logic [15:0] XA_WAKE_CFG = 16'h4000;
    localparam logic [15:0] XA_INT_CFG  = 16'h4003;
    localparam logic [15:0] XA_WADDR0   = 16'h4004;   // most significant word
    localparam int          WADDR_WORDS = 3;

    // Field positions
    localparam int CTRL_LOOP_BIT  = 14;
    localparam int CTRL_ISO_BIT   = 10;
    localparam int WCFG_EN_BIT    = 2;
    localparam int ICFG_PULSE_BIT = 7;
    localparam int ICFG_WIDTH_LSB = 8;

    // Opcodes
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        S_PRE, S_ST, S_HDR, S_WTA, S_WR, S_RTA, S_RD, S_REND
    } fr_state_e;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_win_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int PRE_LEN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_W-1:0]  reg_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int HDR_BITS = 2 + PHY_W + REG_W;
    localparam int ONES_W   = $clog2(PRE_LEN + 1);
    localparam int CNT_W    = $clog2(DATA_W);

    typedef struct packed {
        fr_state_e          st;
        logic [ONES_W-1:0]  ones;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  sh;
        logic [REG_W-1:0]   ra;
        logic               oe;
        logic               o;
    } fsm_t;

    fsm_t q, d;
    logic [HDR_BITS-1:0] hdr;

    assign hdr = {q.sh[HDR_BITS-2:0], mdio_i};

    always_comb begin
        d      = q;
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        case (q.st)
            S_PRE: begin
                if (mdio_i) begin
                    if (q.ones != ONES_W'(PRE_LEN)) d.ones = q.ones + 1'b1;
                end else begin
                    if (q.ones == ONES_W'(PRE_LEN)) d.st = S_ST;
                    d.ones = '0;
                end
            end
            S_ST: begin
                d.cnt = '0;
                d.st  = mdio_i ? S_HDR : S_PRE;
            end
            S_HDR: begin
                d.sh  = {q.sh[DATA_W-2:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(HDR_BITS - 1)) begin
                    d.cnt = '0;
                    d.ra  = hdr[REG_W-1:0];
                    if (hdr[REG_W +: PHY_W] != phy_addr)     d.st = S_PRE;
                    else if (hdr[HDR_BITS-1 -: 2] == OP_RD)  d.st = S_RTA;
                    else if (hdr[HDR_BITS-1 -: 2] == OP_WR)  d.st = S_WTA;
                    else                                     d.st = S_PRE;
                end
            end
            S_WTA: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(1)) begin
                    d.cnt = '0;
                    d.st  = S_WR;
                end
            end
            S_WR: begin
                d.sh  = {q.sh[DATA_W-2:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) begin
                    wr_stb = 1'b1;
                    d.st   = S_PRE;
                end
            end
            S_RTA: begin
                rd_stb = 1'b1;
                d.oe   = 1'b1;
                d.o    = 1'b0;
                d.sh   = rd_data;
                d.cnt  = '0;
                d.st   = S_RD;
            end
            S_RD: begin
                d.o   = q.sh[DATA_W-1];
                d.sh  = {q.sh[DATA_W-2:0], 1'b0};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) d.st = S_REND;
            end
            S_REND: begin
                d.oe = 1'b0;
                d.o  = 1'b0;
                d.st = S_PRE;
            end
            default: d.st = S_PRE;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_addr = q.ra;
    assign wr_data  = {q.sh[DATA_W-2:0], mdio_i};
    assign mdio_o   = q.o;
    assign mdio_oe  = q.oe;

    // R2: the driver turns on with the turnaround zero
    p_ta_zero_r2: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);
    // R2: release of MDIO only at the end of a frame
    p_release_end_r2: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (q.st == S_PRE));
    // R4: never drive while receiving write data or a header
    p_no_drive_wr_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == S_WR || q.st == S_HDR || q.st == S_WTA) |-> !mdio_oe);

endmodule

// File: rtl/mdio_ext_bank.sv
module mdio_ext_bank
    import mdio_win_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int XA_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [XA_W-1:0]               addr,
    input  logic                          wr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic                          wake_en,
    output logic                          pulse_mode,
    output logic [1:0]                    pulse_width,
    output logic [WADDR_WORDS*DATA_W-1:0] wake_addr
);
    typedef struct packed {
        logic [WADDR_WORDS-1:0][DATA_W-1:0] wa;
        logic [DATA_W-1:0]                  wcfg;
        logic [DATA_W-1:0]                  icfg;
    } ext_t;

    ext_t q, d;

    always_comb begin
        d     = q;
        rdata = '0;
        if (addr == XA_W'(XA_WAKE_CFG)) begin
            rdata = q.wcfg;
            if (wr) d.wcfg = wdata;
        end
        if (addr == XA_W'(XA_INT_CFG)) begin
            rdata = q.icfg;
            if (wr) d.icfg = wdata;
        end
        for (int i = 0; i < WADDR_WORDS; i++) begin
            if (addr == XA_W'(XA_WADDR0) + XA_W'(i)) begin
                rdata = q.wa[i];
                if (wr) d.wa[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wake_en     = q.wcfg[WCFG_EN_BIT];
    assign pulse_mode  = q.icfg[ICFG_PULSE_BIT];
    assign pulse_width = q.icfg[ICFG_WIDTH_LSB +: 2];

    for (genvar g = 0; g < WADDR_WORDS; g++) begin : g_waddr
        assign wake_addr[(WADDR_WORDS-1-g)*DATA_W +: DATA_W] = q.wa[g];
    end

    // R7: a write to an unused extended address leaves the bank untouched
    p_ext_unimpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != XA_W'(XA_WAKE_CFG) && addr != XA_W'(XA_INT_CFG) &&
         (addr < XA_W'(XA_WADDR0) || addr >= XA_W'(XA_WADDR0) + XA_W'(WADDR_WORDS)))
        |=> $stable(q));

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_win_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 5,
    parameter int XA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] x_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [XA_W-1:0]   x_addr,
    output logic              x_wr,
    output logic              loopback,
    output logic              isolate,
    output logic              irq_n
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] istat;
        logic [XA_W-1:0]   xaddr;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (rd_stb && reg_addr == REG_W'(RA_ISTAT)) d.istat = '0;
        d.istat = d.istat | evt;
        if (wr_stb) begin
            case (reg_addr)
                REG_W'(RA_CTRL):  d.ctrl  = wr_data;
                REG_W'(RA_IMASK): d.imask = wr_data;
                REG_W'(RA_XADDR): d.xaddr = wr_data[XA_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            REG_W'(RA_CTRL):  rd_data = q.ctrl;
            REG_W'(RA_IMASK): rd_data = q.imask;
            REG_W'(RA_ISTAT): rd_data = q.istat;
            REG_W'(RA_XADDR): rd_data = DATA_W'(q.xaddr);
            REG_W'(RA_XDATA): rd_data = x_rdata;
            default:          rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign x_addr   = q.xaddr;
    assign x_wr     = wr_stb && (reg_addr == REG_W'(RA_XDATA));
    assign loopback = q.ctrl[CTRL_LOOP_BIT];
    assign isolate  = q.ctrl[CTRL_ISO_BIT];
    assign irq_n    = ~|(q.istat & q.imask);

    // R10: status bits are sticky unless a read of the status word happens
    p_stat_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && reg_addr == REG_W'(RA_ISTAT)) |=> (($past(q.istat) & ~q.istat) == '0));
    // R10 / R12: an event always lands in the status word
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((q.istat & $past(evt)) == $past(evt)));
    // R7: a write to an unimplemented direct register changes nothing
    p_unimpl_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_addr != REG_W'(RA_CTRL) && reg_addr != REG_W'(RA_IMASK) &&
         reg_addr != REG_W'(RA_XADDR))
        |=> $stable({q.ctrl, q.imask, q.xaddr}));

endmodule

// File: rtl/mdio_window_slave.sv
module mdio_window_slave
    import mdio_win_pkg::*;
#(
    parameter int PHY_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic                          mdc,
    input  logic                          rst_n,
    input  logic [PHY_W-1:0]              strap_phy_addr,
    input  logic                          mdio_i,
    output logic                          mdio_o,
    output logic                          mdio_oe,
    input  logic [DATA_W-1:0]             irq_evt,
    output logic                          irq_n,
    output logic                          loopback_en,
    output logic                          isolate_en,
    output logic                          wake_en,
    output logic                          wake_pulse_mode,
    output logic [1:0]                    wake_pulse_width,
    output logic [WADDR_WORDS*DATA_W-1:0] wake_addr
);
    localparam int REG_W = 5;
    localparam int XA_W  = 16;

    typedef struct packed {
        logic [PHY_W-1:0] phy;
        logic             latched;
    } strap_t;

    strap_t sq, sd;

    always_comb begin
        sd = sq;
        if (!sq.latched) begin
            sd.phy     = strap_phy_addr;
            sd.latched = 1'b1;
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) sq <= '0;
        else        sq <= sd;
    end

    logic [REG_W-1:0]  reg_addr;
    logic              rd_stb, wr_stb;
    logic [DATA_W-1:0] wr_data, rd_data, x_rdata;
    logic [XA_W-1:0]   x_addr;
    logic              x_wr;

    mdio_frame_fsm #(
        .DATA_W(DATA_W), .PHY_W(PHY_W), .REG_W(REG_W), .PRE_LEN(PRE_LEN)
    ) u_fsm (
        .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .phy_addr(sq.phy),
        .rd_data(rd_data), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    mdio_regfile #(
        .DATA_W(DATA_W), .REG_W(REG_W), .XA_W(XA_W)
    ) u_rf (
        .clk(mdc), .rst_n(rst_n), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .evt(irq_evt), .x_rdata(x_rdata),
        .rd_data(rd_data), .x_addr(x_addr), .x_wr(x_wr),
        .loopback(loopback_en), .isolate(isolate_en), .irq_n(irq_n)
    );

    mdio_ext_bank #(
        .DATA_W(DATA_W), .XA_W(XA_W)
    ) u_ext (
        .clk(mdc), .rst_n(rst_n), .addr(x_addr), .wr(x_wr), .wdata(wr_data),
        .rdata(x_rdata), .wake_en(wake_en), .pulse_mode(wake_pulse_mode),
        .pulse_width(wake_pulse_width), .wake_addr(wake_addr)
    );

    // R5: once captured, the PHY address never moves
    p_strap_hold_r5: assert property (@(posedge mdc) disable iff (!rst_n)
        sq.latched |=> (sq.latched && $stable(sq.phy)));

endmodule

// File: tb/mdio_window_slave_test.sv
module mdio_window_slave_test;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_phy_addr = 5'h0B;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe, irq_n;
    logic [15:0] irq_evt = '0;
    logic        loopback_en, isolate_en, wake_en, wake_pulse_mode;
    logic [1:0]  wake_pulse_width;
    logic [47:0] wake_addr;

    int errors = 0;
    int checks = 0;

    localparam logic [4:0] MY_PHY = 5'h0B;
    localparam logic [4:0] LATE_STRAP = 5'h03;

    always #4 mdc = ~mdc;

    mdio_window_slave uut (
        .mdc(mdc), .rst_n(rst_n), .strap_phy_addr(strap_phy_addr),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .irq_evt(irq_evt), .irq_n(irq_n), .loopback_en(loopback_en),
        .isolate_en(isolate_en), .wake_en(wake_en),
        .wake_pulse_mode(wake_pulse_mode), .wake_pulse_width(wake_pulse_width),
        .wake_addr(wake_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_i = b;
    endtask

    task automatic wr_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] dat);
        if (pre < 32) send_bit(1'b0);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        send_bit(1'b1); send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(dat[i]);
        @(negedge mdc);
        mdio_i = 1'b1;
    endtask

    task automatic rd_frame(input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] evt_at_cap,
                            output logic [15:0] dat, output logic ta_ok,
                            output logic saw_oe);
        for (int i = 0; i < 32; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b0);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        @(negedge mdc);
        mdio_i  = 1'b1;
        ta_ok   = (mdio_oe == 1'b0);
        saw_oe  = mdio_oe;
        irq_evt = evt_at_cap;
        @(negedge mdc);
        irq_evt = '0;
        ta_ok   = ta_ok && mdio_oe && !mdio_o;
        saw_oe  = saw_oe | mdio_oe;
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            dat[i] = mdio_o;
            ta_ok  = ta_ok && mdio_oe;
            saw_oe = saw_oe | mdio_oe;
        end
        @(negedge mdc);
        ta_ok  = ta_ok && !mdio_oe;
        saw_oe = saw_oe | mdio_oe;
    endtask

    task automatic rd_check(input string req, input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] d;
        logic ok, oe;
        rd_frame(MY_PHY, ra, 16'h0, d, ok, oe);
        chk({req, " read data"}, 64'(d), 64'(exp));
        chk("R2 turnaround and release", 64'(ok), 64'd1);
    endtask

    task automatic ext_write(input logic [15:0] xa, input logic [15:0] v);
        wr_frame(32, 2'b01, MY_PHY, 5'h1E, xa);
        wr_frame(32, 2'b01, MY_PHY, 5'h1F, v);
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge mdc);
        irq_evt = v;
        @(negedge mdc);
        irq_evt = '0;
    endtask

    task automatic t_reset;
        chk("R1 mdio_oe", 64'(mdio_oe), 64'd0);
        chk("R1 mdio_o", 64'(mdio_o), 64'd0);
        chk("R1 irq_n", 64'(irq_n), 64'd1);
        chk("R1 controls", 64'({loopback_en, isolate_en, wake_en, wake_pulse_mode,
                                wake_pulse_width}), 64'd0);
        chk("R1 wake_addr", 64'(wake_addr), 64'd0);
    endtask

    task automatic t_ctrl;
        wr_frame(32, 2'b01, MY_PHY, 5'h00, 16'h4400);
        chk("R3 loopback_en", 64'(loopback_en), 64'd1);
        chk("R3 isolate_en", 64'(isolate_en), 64'd1);
        rd_check("R3", 5'h00, 16'h4400);
        wr_frame(32, 2'b01, MY_PHY, 5'h00, 16'h4001);
        chk("R3 isolate cleared", 64'({loopback_en, isolate_en}), 64'b10);
        rd_check("R3", 5'h00, 16'h4001);
    endtask

    task automatic t_ignored;
        logic [15:0] d;
        logic ok, oe;
        // R5: the strap pins now show LATE_STRAP, which must not be answered
        wr_frame(32, 2'b01, LATE_STRAP, 5'h00, 16'h0000);
        chk("R5 late strap address ignored", 64'(loopback_en), 64'd1);
        rd_frame(LATE_STRAP, 5'h00, 16'h0, d, ok, oe);
        chk("R4 foreign read never drives", 64'(oe), 64'd0);
        wr_frame(32, 2'b11, MY_PHY, 5'h00, 16'h0000);
        chk("R4 opcode 11 ignored", 64'(loopback_en), 64'd1);
        wr_frame(32, 2'b00, MY_PHY, 5'h00, 16'h0000);
        chk("R4 opcode 00 ignored", 64'(loopback_en), 64'd1);
        wr_frame(31, 2'b01, MY_PHY, 5'h00, 16'h0000);
        chk("R6 short preamble ignored", 64'(loopback_en), 64'd1);
        rd_check("R6", 5'h00, 16'h4001);
    endtask

    task automatic t_unimpl;
        wr_frame(32, 2'b01, MY_PHY, 5'h05, 16'hFFFF);
        rd_check("R7 direct unimplemented", 5'h05, 16'h0000);
        rd_check("R7 control untouched", 5'h00, 16'h4001);
        ext_write(16'h1234, 16'hFFFF);
        rd_check("R7 extended unimplemented", 5'h1F, 16'h0000);
    endtask

    task automatic t_window;
        ext_write(16'h4004, 16'hAAAA);
        ext_write(16'h4005, 16'hBBBB);
        ext_write(16'h4006, 16'hCCCC);
        chk("R8 wake_addr", 64'(wake_addr), 64'hAAAABBBBCCCC);
        rd_check("R8 offset register", 5'h1E, 16'h4006);
        rd_check("R8 data window", 5'h1F, 16'hCCCC);
        wr_frame(32, 2'b01, MY_PHY, 5'h1E, 16'h4004);
        rd_check("R8 high word", 5'h1F, 16'hAAAA);
    endtask

    task automatic t_wake_cfg;
        ext_write(16'h4000, 16'h0004);
        chk("R9 wake_en", 64'(wake_en), 64'd1);
        ext_write(16'h4003, 16'h0280);
        chk("R9 pulse mode", 64'(wake_pulse_mode), 64'd1);
        chk("R9 pulse width", 64'(wake_pulse_width), 64'd2);
        rd_check("R9 readback", 5'h1F, 16'h0280);
        ext_write(16'h4003, 16'h0100);
        chk("R9 level mode width 1", 64'({wake_pulse_mode, wake_pulse_width}), 64'b001);
    endtask

    task automatic t_status;
        pulse_evt(16'h0040);
        chk("R11 masked event keeps irq_n high", 64'(irq_n), 64'd1);
        rd_check("R10 wake status", 5'h13, 16'h0040);
        rd_check("R10 cleared by read", 5'h13, 16'h0000);
        pulse_evt(16'h0010);
        wr_frame(32, 2'b01, MY_PHY, 5'h13, 16'h0000);
        rd_check("R10 write to status discarded", 5'h13, 16'h0010);
        wr_frame(32, 2'b01, MY_PHY, 5'h12, 16'h0040);
        rd_check("R11 mask readback", 5'h12, 16'h0040);
        pulse_evt(16'h0008);
        chk("R11 unmasked bit only", 64'(irq_n), 64'd1);
        pulse_evt(16'h0040);
        chk("R11 irq asserted", 64'(irq_n), 64'd0);
        rd_check("R10 both events", 5'h13, 16'h0048);
        chk("R11 irq released after read", 64'(irq_n), 64'd1);
    endtask

    task automatic t_race;
        logic [15:0] d;
        logic ok, oe;
        rd_frame(MY_PHY, 5'h13, 16'h0040, d, ok, oe);
        chk("R12 read returns old status", 64'(d), 64'd0);
        chk("R12 irq from surviving event", 64'(irq_n), 64'd0);
        rd_check("R12 event survived clear", 5'h13, 16'h0040);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge mdc);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge mdc);
        strap_phy_addr = LATE_STRAP;
        t_ctrl();
        t_ignored();
        t_unimpl();
        t_window();
        t_wake_cfg();
        t_status();
        t_race();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule